// File: doc/BRIEF.md
# Camera Pixel Capture Port

This block takes pixel words from an external image sensor that supplies its own pixel clock, so the block only listens and never drives a clock. On each rising pixel-clock edge it registers a 16-bit data word together with three line and frame qualifiers. Each qualifier has its own polarity control. A word is taken only when all three qualifiers are active in the same sample, and only while the capture enable and the camera-mode enable are both set. After enabling, capture waits for the next rising edge of the frame qualifier, so a frame already under way is never delivered in part.

Accepted words, each tagged with a frame-start and a line-start marker, pass through a 16-entry asynchronous FIFO with Gray-coded pointers. They leave in the system clock domain on a valid/ready stream. When the FIFO is full, the incoming word is discarded and a sticky overflow flag is raised in the system domain. Software clears the flag with a one-cycle write-one-to-clear pulse.

Top module: `cam_pixel_capture`

## Requirements
- R1: After reset, `m_valid` and `ovf_flag` are both low.
- R2: A word is delivered only if, at one rising pixel-clock edge, the horizontal sync, vertical sync and horizontal enable inputs are all at their active level. Words sampled with any qualifier inactive are never delivered.
- R3: Each qualifier has an inversion control. With the control at 0, the qualifier is active high. With the control at 1, it is active low.
- R4: Capture needs both `cfg_enable` and `cfg_cam_mode` at 1. With either one at 0, no word is delivered.
- R5: Once capture is enabled, the first word taken is the first one after a new inactive-to-active edge of vertical sync. Words from a frame that began before the enable are dropped.
- R6: `m_sof` is 1 on the first delivered word after vertical sync becomes active, and 0 on all other words of that frame.
- R7: `m_sol` is 1 on the first delivered word after horizontal enable becomes active, and 0 on the other words of that line.
- R8: While the FIFO has room, accepted words reach the system side in capture order, with no loss and no duplication.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data`, `m_sof` and `m_sol` hold their values.
- R10: With 16 words stored, each further accepted word is discarded and `ovf_flag` is set. The flag stays set until it is cleared.
- R11: A 1 on `ovf_clr` for one system clock clears `ovf_flag` at that edge, unless a new overflow arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the block synchronizes it into the pixel domain itself |
| pclk | input | 1 | Pixel clock from the camera |
| cfg_enable | input | 1 | Capture enable (system domain) |
| cfg_cam_mode | input | 1 | Camera-mode enable (system domain) |
| cfg_inv_hsync | input | 1 | 1 = horizontal sync is active low |
| cfg_inv_vsync | input | 1 | 1 = vertical sync is active low |
| cfg_inv_hen | input | 1 | 1 = horizontal enable is active low |
| cam_data | input | DATA_W | Camera pixel data bus |
| cam_hsync | input | 1 | Horizontal sync qualifier |
| cam_vsync | input | 1 | Vertical sync qualifier |
| cam_hen | input | 1 | Horizontal enable qualifier |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | DATA_W | Output pixel word |
| m_sof | output | 1 | Frame-start marker for the current word |
| m_sol | output | 1 | Line-start marker for the current word |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, a 16-entry FIFO and two-flop synchronizers. With a pixel clock of 24 ns against the 5 ns system clock, the FIFO almost never fills while the consumer is ready. The full and overflow path is therefore reached on purpose: the consumer is held off while a 20-word line is captured, which forces exactly four discards. The small depth keeps that case, and the Gray pointer wrap that the later drain produces, within a short run. The test also covers polarity flips, the mid-frame enable and backpressure holds.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    // Markers carried next to each captured word.
    typedef struct packed {
        logic sof;
        logic sol;
    } cam_mark_t;

    // True when all three qualifiers are at their active level.
    function automatic logic all_active(input logic hs, input logic vs, input logic he);
        return hs & vs & he;
    endfunction

endpackage

// File: rtl/cam_cap_sync.sv
module cam_cap_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cam_cap_front.sv
module cam_cap_front
    import cam_cap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              en_live,
    input  logic              inv_hs,
    input  logic              inv_vs,
    input  logic              inv_he,
    input  logic [DATA_W-1:0] cam_data,
    input  logic              cam_hsync,
    input  logic              cam_vsync,
    input  logic              cam_hen,
    input  logic              wr_full,
    output logic              wr_req,
    output logic [DATA_W+1:0] wr_word,
    output logic              ovf_tgl
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              hs;       // active level, polarity already applied
        logic              vs;
        logic              he;
        logic              vs_prev;
        logic              he_prev;
        logic              armed;
        logic              sof_pend;
        logic              sol_pend;
        logic              tgl;
    } front_t;

    front_t    d, q;
    logic      vs_rise, he_rise, arm_now, take;
    cam_mark_t mark;

    always_comb begin
        vs_rise  = q.vs & ~q.vs_prev;
        he_rise  = q.he & ~q.he_prev;
        arm_now  = en_live & (q.armed | vs_rise);
        take     = arm_now & all_active(q.hs, q.vs, q.he);
        mark.sof = q.sof_pend | vs_rise;
        mark.sol = q.sol_pend | he_rise;

        d          = q;
        d.data     = cam_data;
        d.hs       = cam_hsync ^ inv_hs;
        d.vs       = cam_vsync ^ inv_vs;
        d.he       = cam_hen ^ inv_he;
        d.vs_prev  = q.vs;
        d.he_prev  = q.he;
        d.armed    = arm_now;
        d.sof_pend = take ? 1'b0 : mark.sof;
        d.sol_pend = take ? 1'b0 : mark.sol;
        if (take && wr_full) d.tgl = ~q.tgl;

        wr_req  = take & ~wr_full;
        wr_word = {mark, q.data};
        ovf_tgl = q.tgl;
    end

    always_ff @(posedge pclk or negedge prst_n) begin
        if (!prst_n) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/cam_cap_afifo.sv
module cam_cap_afifo #(
    parameter int WORD_W      = 18,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t              w_d, w_q, r_d, r_q;
    logic [PW-1:0]     rgray_w, wgray_r;
    logic [WORD_W-1:0] mem [DEPTH];
    logic              push, pop;

    cam_cap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .din(r_q.gray), .dout(rgray_w)
    );
    cam_cap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .din(w_q.gray), .dout(wgray_r)
    );

    // Write side
    always_comb begin
        wr_full = (w_q.gray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
        push    = wr_en & ~wr_full;
        w_d     = w_q;
        if (push) begin
            w_d.bin  = w_q.bin + PW'(1);
            w_d.gray = (w_d.bin >> 1) ^ w_d.bin;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (push) mem[w_q.bin[ADDR_W-1:0]] <= wr_data;
    end

    // Read side
    always_comb begin
        rd_empty = (r_q.gray == wgray_r);
        pop      = rd_en & ~rd_empty;
        rd_data  = mem[r_q.bin[ADDR_W-1:0]];
        r_d      = r_q;
        if (pop) begin
            r_d.bin  = r_q.bin + PW'(1);
            r_d.gray = (r_d.bin >> 1) ^ r_d.bin;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end
endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture
    import cam_cap_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              cfg_enable,
    input  logic              cfg_cam_mode,
    input  logic              cfg_inv_hsync,
    input  logic              cfg_inv_vsync,
    input  logic              cfg_inv_hen,
    input  logic [DATA_W-1:0] cam_data,
    input  logic              cam_hsync,
    input  logic              cam_vsync,
    input  logic              cam_hen,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_sof,
    output logic              m_sol,
    output logic              ovf_flag,
    input  logic              ovf_clr
);
    localparam int ADDR_W = $clog2(FIFO_DEPTH);
    localparam int WORD_W = DATA_W + 2;

    typedef struct packed {
        logic tgl_seen;
        logic flag;
    } ovf_t;

    logic              prst_n, en_live, wr_req, wr_full, rd_empty;
    logic              ovf_tgl, ovf_tgl_s, ovf_evt;
    logic [WORD_W-1:0] wr_word, rd_word;
    cam_mark_t         rd_mark;
    ovf_t              ov_d, ov_q;

    // Pixel-domain reset: asserts at once, releases on pclk
    cam_cap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_prst (
        .clk(pclk), .rst_n(rst_n), .din(1'b1), .dout(prst_n)
    );

    cam_cap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ensync (
        .clk(pclk), .rst_n(prst_n), .din(cfg_enable & cfg_cam_mode), .dout(en_live)
    );

    cam_cap_front #(.DATA_W(DATA_W)) u_front (
        .pclk     (pclk),
        .prst_n   (prst_n),
        .en_live  (en_live),
        .inv_hs   (cfg_inv_hsync),
        .inv_vs   (cfg_inv_vsync),
        .inv_he   (cfg_inv_hen),
        .cam_data (cam_data),
        .cam_hsync(cam_hsync),
        .cam_vsync(cam_vsync),
        .cam_hen  (cam_hen),
        .wr_full  (wr_full),
        .wr_req   (wr_req),
        .wr_word  (wr_word),
        .ovf_tgl  (ovf_tgl)
    );

    cam_cap_afifo #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .wclk    (pclk),
        .wrst_n  (prst_n),
        .wr_en   (wr_req),
        .wr_data (wr_word),
        .wr_full (wr_full),
        .rclk    (clk),
        .rrst_n  (rst_n),
        .rd_en   (m_ready),
        .rd_data (rd_word),
        .rd_empty(rd_empty)
    );

    cam_cap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovfsync (
        .clk(clk), .rst_n(rst_n), .din(ovf_tgl), .dout(ovf_tgl_s)
    );

    always_comb begin
        rd_mark       = rd_word[WORD_W-1 -: 2];
        m_valid       = ~rd_empty;
        m_data        = rd_word[DATA_W-1:0];
        m_sof         = rd_mark.sof;
        m_sol         = rd_mark.sol;

        ovf_evt       = ovf_tgl_s ^ ov_q.tgl_seen;
        ov_d.tgl_seen = ovf_tgl_s;
        ov_d.flag     = ovf_evt | (ov_q.flag & ~ovf_clr);
        ovf_flag      = ov_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ov_q <= '0;
        else        ov_q <= ov_d;
    end
endmodule

// File: rtl/cam_cap_checker.sv
module cam_cap_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pclk,
    input logic              prst_n,
    input logic              cfg_inv_hsync,
    input logic              cfg_inv_vsync,
    input logic              cfg_inv_hen,
    input logic              cam_hsync,
    input logic              cam_vsync,
    input logic              cam_hen,
    input logic              wr_req,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_sof,
    input logic              m_sol,
    input logic              ovf_flag,
    input logic              ovf_clr,
    input logic              ovf_evt
);
    // R2 / R3: a FIFO write needs all three qualifiers active at the previous sample
    p_gate_r2: assert property (@(posedge pclk) disable iff (!prst_n)
        wr_req |-> $past((cam_hsync ^ cfg_inv_hsync) && (cam_vsync ^ cfg_inv_vsync)
                         && (cam_hen ^ cfg_inv_hen)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_sol)));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_evt) |=> !ovf_flag);

    p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
endmodule

bind cam_pixel_capture cam_cap_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .prst_n(prst_n),
    .cfg_inv_hsync(cfg_inv_hsync), .cfg_inv_vsync(cfg_inv_vsync), .cfg_inv_hen(cfg_inv_hen),
    .cam_hsync(cam_hsync), .cam_vsync(cam_vsync), .cam_hen(cam_hen),
    .wr_req(wr_req), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_sol(m_sol), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .ovf_evt(ovf_evt)
);

// File: tb/test_cam_pixel_capture.sv
`timescale 1ns/1ps
module test_cam_pixel_capture;
    logic        clk = 0, pclk = 0, rst_n = 0;
    logic        cfg_enable = 0, cfg_cam_mode = 0;
    logic        cfg_inv_hsync = 0, cfg_inv_vsync = 0, cfg_inv_hen = 0;
    logic [15:0] cam_data = 0;
    logic        cam_hsync = 0, cam_vsync = 0, cam_hen = 0;
    logic        m_valid, m_ready = 1, m_sof, m_sol, ovf_flag, ovf_clr = 0;
    logic [15:0] m_data;

    int vectors = 0, fails = 0, cyc = 0;
    int rx_cnt = 0, sof_cnt = 0, sol_cnt = 0;

    // reference model state
    logic [17:0] expq[$];
    bit mv_prev = 0, mh_prev = 0, m_armed = 0, m_sofp = 0, m_solp = 0, exp_ovf = 0;

    always #2.5 clk = ~clk;   // 200 MHz
    always #12  pclk = ~pclk;

    cam_pixel_capture i_cam_pixel_capture (
        .clk(clk), .rst_n(rst_n), .pclk(pclk),
        .cfg_enable(cfg_enable), .cfg_cam_mode(cfg_cam_mode),
        .cfg_inv_hsync(cfg_inv_hsync), .cfg_inv_vsync(cfg_inv_vsync), .cfg_inv_hen(cfg_inv_hen),
        .cam_data(cam_data), .cam_hsync(cam_hsync), .cam_vsync(cam_vsync), .cam_hen(cam_hen),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_sol(m_sol),
        .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Pixel-side model: what the requirements say each sample does
    always @(posedge pclk) begin
        bit hs, vs, he, vr, hr, arm;
        hs = cam_hsync ^ cfg_inv_hsync;
        vs = cam_vsync ^ cfg_inv_vsync;
        he = cam_hen ^ cfg_inv_hen;
        vr = vs && !mv_prev;
        hr = he && !mh_prev;
        arm = cfg_enable && cfg_cam_mode && (m_armed || vr);
        if (arm && hs && vs && he) begin
            if (expq.size() >= 16) exp_ovf = 1;
            else expq.push_back({m_sofp | vr, m_solp | hr, cam_data});
            m_sofp = 0;
            m_solp = 0;
        end else begin
            m_sofp = m_sofp | vr;
            m_solp = m_solp | hr;
        end
        m_armed = arm;
        mv_prev = vs;
        mh_prev = he;
    end

    // System-side compare on every clock (R8, R6, R7)
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            vectors++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R8: actual word %h expected none", {m_sof, m_sol, m_data});
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                if ({m_sof, m_sol, m_data} !== e) begin
                    fails++;
                    $display("FAIL R8/R6/R7: actual %h expected %h", {m_sof, m_sol, m_data}, e);
                end
            end
            rx_cnt++;
            if (m_sof) sof_cnt++;
            if (m_sol) sol_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic put(input bit h, input bit v, input bit e, input logic [15:0] d);
        @(negedge pclk);
        cam_hsync = h ^ cfg_inv_hsync;
        cam_vsync = v ^ cfg_inv_vsync;
        cam_hen   = e ^ cfg_inv_hen;
        cam_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 0, 0, 16'h0);
    endtask

    task automatic set_inv(input bit h, input bit v, input bit e);
        @(negedge pclk);
        cfg_inv_hsync = h; cfg_inv_vsync = v; cfg_inv_hen = e;
        cam_hsync = h; cam_vsync = v; cam_hen = e;
    endtask

    // Frame with junk samples where only two qualifiers are active (R2)
    task automatic frame(input int lines, input int px, input logic [15:0] base);
        idle(2);
        put(0, 1, 0, 16'hdead);
        put(0, 1, 0, 16'hdead);
        for (int l = 0; l < lines; l++) begin
            put(1, 1, 0, 16'hbad1);
            for (int p = 0; p < px; p++) put(1, 1, 1, base + 16'(l * 32 + p));
            put(0, 1, 1, 16'hbad2);
            put(0, 1, 0, 16'hbad3);
        end
        idle(3);
    endtask

    task automatic drain;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (expq.size() == 0 && !m_valid) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic set_ready(input bit r);
        @(posedge clk); #1 m_ready = r;
    endtask

    initial begin
        int base, sofb;
        logic [15:0] hold;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (6) @(negedge clk);
        chk(m_valid == 0, "R1", m_valid, 0);
        chk(ovf_flag == 0, "R1", ovf_flag, 0);

        cfg_enable = 1; cfg_cam_mode = 1;
        idle(8);
        base = rx_cnt;
        frame(3, 4, 16'h1000);
        drain();
        chk(rx_cnt - base == 12, "R2", rx_cnt - base, 12);
        chk(sof_cnt == 1, "R6", sof_cnt, 1);
        chk(sol_cnt == 3, "R7", sol_cnt, 3);

        // R3: all qualifiers active low
        set_inv(1, 1, 1);
        idle(8);
        base = rx_cnt; sofb = sof_cnt;
        frame(2, 3, 16'h2000);
        drain();
        chk(rx_cnt - base == 6, "R3", rx_cnt - base, 6);
        chk(sof_cnt - sofb == 1, "R6", sof_cnt - sofb, 1);
        set_inv(0, 1, 0);
        idle(8);
        base = rx_cnt;
        frame(1, 4, 16'h2800);
        drain();
        chk(rx_cnt - base == 4, "R3", rx_cnt - base, 4);
        set_inv(0, 0, 0);

        // R4: each enable alone is not enough
        cfg_cam_mode = 0;
        idle(8);
        base = rx_cnt;
        frame(2, 3, 16'h3000);
        drain();
        chk(rx_cnt == base, "R4", rx_cnt - base, 0);
        cfg_cam_mode = 1; cfg_enable = 0;
        idle(8);
        frame(2, 3, 16'h3100);
        drain();
        chk(rx_cnt == base, "R4", rx_cnt - base, 0);

        // R5: enable mid-frame, that frame is skipped
        idle(2);
        for (int i = 0; i < 3; i++) put(0, 1, 0, 16'h0);
        cfg_enable = 1;
        for (int i = 0; i < 8; i++) put(0, 1, 0, 16'h0);
        for (int l = 0; l < 2; l++) begin
            for (int p = 0; p < 3; p++) put(1, 1, 1, 16'h4000 + 16'(p));
            put(0, 1, 0, 16'h0);
        end
        idle(3);
        drain();
        chk(rx_cnt == base, "R5", rx_cnt - base, 0);
        frame(1, 4, 16'h4100);
        drain();
        chk(rx_cnt - base == 4, "R5", rx_cnt - base, 4);

        // R9: stalled consumer holds the head word
        set_ready(0);
        base = rx_cnt;
        frame(1, 5, 16'h5000);
        repeat (10) @(negedge clk);
        chk(m_valid == 1, "R9", m_valid, 1);
        hold = m_data;
        repeat (10) @(negedge clk);
        chk(m_data == hold, "R9", m_data, hold);
        chk(m_valid == 1, "R9", m_valid, 1);
        set_ready(1);
        drain();
        chk(rx_cnt - base == 5, "R8", rx_cnt - base, 5);

        // R10: fill the FIFO with the consumer held off
        set_ready(0);
        repeat (10) @(negedge clk);
        base = rx_cnt;
        frame(1, 20, 16'h6000);
        repeat (20) @(negedge clk);
        chk(ovf_flag == 1, "R10", ovf_flag, 1);
        chk(exp_ovf == 1, "R10", exp_ovf, 1);
        set_ready(1);
        drain();
        chk(rx_cnt - base == 16, "R10", rx_cnt - base, 16);
        chk(ovf_flag == 1, "R10", ovf_flag, 1);

        // R11: write-one-to-clear
        @(posedge clk); #1 ovf_clr = 1;
        @(posedge clk); #1 ovf_clr = 0;
        @(negedge clk);
        chk(ovf_flag == 0, "R11", ovf_flag, 0);

        chk(expq.size() == 0, "R8", expq.size(), 0);
        summary();
        $finish;
    end
endmodule